// File: doc/BRIEF.md
# Sub-Pulse Spread PWM Generator

This block turns a 14-bit duty value into a pulse-width-modulated output whose high time is split across 64 short sub-pulses per conversion period, rather than one long pulse. An analog low-pass filter placed after it then sees a ripple frequency 64 times higher than a single-pulse PWM with the same period would give. Every sub-pulse receives a common base high time. The leftover fraction of the duty is handed out one unit at a time to sub-pulses chosen in bit-reversed index order, so the extra units are spread evenly across the period.

Software reaches the block through three write strobes that share one byte-wide data bus. The control register sets the time base and the output enable. The duty value is written as a low byte first and a high byte second. The high-byte write combines both bytes into a pending value. The waveform generator takes in the pending value only when a new conversion period starts, so a period never mixes two duty values. Default parameters give 64 sub-pulses of 256 half-step units each. The sub-pulse count and the sub-pulse length are parameters, and the data width is derived from them.

Top module: `spread_pwm14`

## Requirements
- R1: After reset, pwm_o is 0, the output enable is cleared, the rate code is 0 and both the pending and the working duty values are 0.
- R2: A control write (wr_ctl) takes wdata[1:0] as rate code c and wdata[2] as the output enable. One half-step unit then lasts 2^c clocks. A conversion period is NSUB×UNITS units: with defaults, 16384, 32768, 65536 or 131072 clocks for codes 0 to 3.
- R3: With the output enabled and a stable duty value d, pwm_o is high for min(d + NSUB, NSUB×UNITS) units in every conversion period. With defaults this is (d + 64) × tø/2 with tø = 2^(c+1) clocks, saturating at a fully high period.
- R4: Each sub-pulse is high for one run that starts at its first unit. The run lasts floor(d/NSUB)+1 or floor(d/NSUB)+2 units, and exactly d mod NSUB sub-pulses per period get the longer run.
- R5: Sub-pulse k gets the extra unit exactly when its index with the bits reversed is less than d mod NSUB.
- R6: A wr_lo write stores wdata as duty bits [7:0]. A wr_hi write forms the pending value from wdata[DW-9:0] as the upper bits and the stored low byte as the lower bits. Higher wdata bits are ignored. The working value copies the pending value only when a conversion period wraps, so the rest of the current period keeps the old duty.
- R7: A wr_lo write that is not followed by a wr_hi write never changes the output waveform.
- R8: While the output enable is cleared, pwm_o stays at the idle level (parameter IDLE_LEVEL, default 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_ctl | input | 1 | Write strobe for rate code and output enable |
| wr_lo | input | 1 | Write strobe for the duty low byte |
| wr_hi | input | 1 | Write strobe for the duty high byte, arms the pending value |
| wdata | input | 8 | Write data shared by all three strobes |
| pwm_o | output | 1 | PWM output, or the idle level when disabled |

## Verification
The hardest situation to reach from the ports is a high-byte write that lands inside a period. That case is what shows the old duty value is kept until the wrap. The bench programs a duty whose remainder is 1, so only sub-pulse 0 carries a two-unit run. It watches the output until it sees that run, which marks a period start, and then writes a new value. It then checks that the next seven runs keep the old length and that the following run has the new one. Because the bench runs without phase alignment, totals are measured over arbitrary one-period windows, and sub-pulse patterns are matched against every rotation of the expected sequence.

// File: rtl/spwm_pkg.sv
package spwm_pkg;

   // Half-step unit length selector: unit lasts 2**code system clocks
   typedef enum logic [1:0] {
      RATE_X1 = 2'd0,
      RATE_X2 = 2'd1,
      RATE_X4 = 2'd2,
      RATE_X8 = 2'd3
   } rate_e;

   typedef struct packed {
      logic  en;
      rate_e rate;
   } ctl_t;

   localparam int unsigned RATE_MAX_SHIFT = 3;

endpackage

// File: rtl/spwm_prescale.sv
module spwm_prescale
   import spwm_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  rate_e rate,
   output logic  tick
);
   localparam int unsigned PW = RATE_MAX_SHIFT;

   logic [PW-1:0] cnt_q;
   logic [PW-1:0] lim;

   always_comb begin
      lim  = PW'((4'd1 << rate) - 4'd1);
      // >= keeps the counter live when the rate shrinks mid-count
      tick = (cnt_q >= lim);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (tick) cnt_q <= '0;
      else           cnt_q <= cnt_q + PW'(1);
   end
endmodule

// File: rtl/spwm_frame.sv
module spwm_frame #(
   parameter int unsigned SUB_BITS  = 6,
   parameter int unsigned UNIT_BITS = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick,
   output logic [SUB_BITS-1:0]  sub_q,
   output logic [UNIT_BITS-1:0] unit_q,
   output logic                 wrap
);
   assign wrap = tick & (&unit_q) & (&sub_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         unit_q <= '0;
         sub_q  <= '0;
      end else if (tick) begin
         unit_q <= unit_q + UNIT_BITS'(1);
         if (&unit_q) sub_q <= sub_q + SUB_BITS'(1);
      end
   end
endmodule

// File: rtl/spwm_dbuf.sv
module spwm_dbuf #(
   parameter int unsigned DW = 14
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_lo,
   input  logic          wr_hi,
   input  logic [7:0]    wdata,
   input  logic          wrap,
   output logic [DW-1:0] pend_q,
   output logic [DW-1:0] work_q
);
   localparam int unsigned HW = DW - 8;

   logic [7:0] lo_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q   <= '0;
         pend_q <= '0;
         work_q <= '0;
      end else begin
         if (wr_lo) lo_q   <= wdata;
         if (wr_hi) pend_q <= {wdata[HW-1:0], lo_q};
         if (wrap)  work_q <= pend_q;
      end
   end
endmodule

// File: rtl/spwm_shaper.sv
module spwm_shaper #(
   parameter int unsigned SUB_BITS  = 6,
   parameter int unsigned UNIT_BITS = 8,
   parameter bit          SPREAD    = 1'b1
) (
   input  logic [SUB_BITS+UNIT_BITS-1:0] work,
   input  logic [SUB_BITS-1:0]           sub,
   input  logic [UNIT_BITS-1:0]          unit,
   output logic                          hi
);
   localparam int unsigned DW = SUB_BITS + UNIT_BITS;

   logic [UNIT_BITS-1:0] quot;
   logic [SUB_BITS-1:0]  rem;
   logic [SUB_BITS-1:0]  order;
   logic                 xtra;
   logic [UNIT_BITS:0]   len;

   assign quot = work[DW-1:SUB_BITS];
   assign rem  = work[SUB_BITS-1:0];

   generate
      if (SPREAD) begin : g_rev
         for (genvar i = 0; i < SUB_BITS; i++) begin : g_bit
            assign order[i] = sub[SUB_BITS-1-i];
         end
      end else begin : g_lin
         assign order = sub;
      end
   endgenerate

   always_comb begin
      xtra = (order < rem);
      len  = {1'b0, quot} + (UNIT_BITS+1)'(1) + (UNIT_BITS+1)'(xtra);
      hi   = ({1'b0, unit} < len);
   end
endmodule

// File: rtl/spread_pwm14.sv
module spread_pwm14
   import spwm_pkg::*;
#(
   parameter int unsigned SUB_BITS   = 6,
   parameter int unsigned UNIT_BITS  = 8,
   parameter bit          SPREAD     = 1'b1,
   parameter bit          IDLE_LEVEL = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_ctl,
   input  logic       wr_lo,
   input  logic       wr_hi,
   input  logic [7:0] wdata,
   output logic       pwm_o
);
   localparam int unsigned DW = SUB_BITS + UNIT_BITS;

   initial begin
      assert (DW > 8 && DW <= 16)
         else $fatal(1, "duty width must lie in 9..16");
      assert (SUB_BITS >= 1 && UNIT_BITS >= 1)
         else $fatal(1, "sub-pulse and unit widths must be non-zero");
   end

   ctl_t                 ctl_q;
   logic                 tick;
   logic                 wrap;
   logic [SUB_BITS-1:0]  sub_q;
   logic [UNIT_BITS-1:0] unit_q;
   logic [DW-1:0]        pend_q;
   logic [DW-1:0]        work_q;
   logic                 hi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '{en: 1'b0, rate: RATE_X1};
      end else if (wr_ctl) begin
         ctl_q.rate <= rate_e'(wdata[1:0]);
         ctl_q.en   <= wdata[2];
      end
   end

   spwm_prescale i_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .rate  (ctl_q.rate),
      .tick  (tick)
   );

   spwm_frame #(.SUB_BITS(SUB_BITS), .UNIT_BITS(UNIT_BITS)) i_frame (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .sub_q  (sub_q),
      .unit_q (unit_q),
      .wrap   (wrap)
   );

   spwm_dbuf #(.DW(DW)) i_dbuf (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_lo  (wr_lo),
      .wr_hi  (wr_hi),
      .wdata  (wdata),
      .wrap   (wrap),
      .pend_q (pend_q),
      .work_q (work_q)
   );

   spwm_shaper #(.SUB_BITS(SUB_BITS), .UNIT_BITS(UNIT_BITS), .SPREAD(SPREAD)) i_shape (
      .work (work_q),
      .sub  (sub_q),
      .unit (unit_q),
      .hi   (hi)
   );

   assign pwm_o = ctl_q.en ? hi : IDLE_LEVEL;
endmodule

// File: rtl/spwm_chk.sv
module spwm_chk #(
   parameter int unsigned SUB_BITS   = 6,
   parameter int unsigned UNIT_BITS  = 8,
   parameter bit          IDLE_LEVEL = 1'b0
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          tick,
   input logic                          wrap,
   input logic                          wr_lo,
   input logic                          wr_hi,
   input logic                          en,
   input logic [UNIT_BITS-1:0]          unit_q,
   input logic [SUB_BITS+UNIT_BITS-1:0] pend_q,
   input logic [SUB_BITS+UNIT_BITS-1:0] work_q,
   input logic                          pwm_o
);
   // R2
   unit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(unit_q));

   // R4
   run_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(pwm_o) && en && $past(en)) |-> (unit_q == '0));

   // R6
   work_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap |=> $stable(work_q));

   // R7
   lo_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lo && !wr_hi) |=> $stable(pend_q));

   // R8
   idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> (pwm_o == IDLE_LEVEL));
endmodule

bind spread_pwm14 spwm_chk #(
   .SUB_BITS   (SUB_BITS),
   .UNIT_BITS  (UNIT_BITS),
   .IDLE_LEVEL (IDLE_LEVEL)
) i_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .tick   (tick),
   .wrap   (wrap),
   .wr_lo  (wr_lo),
   .wr_hi  (wr_hi),
   .en     (ctl_q.en),
   .unit_q (unit_q),
   .pend_q (pend_q),
   .work_q (work_q),
   .pwm_o  (pwm_o)
);

// File: tb/test_spread_pwm14.sv
module test_spread_pwm14;
   localparam int CLK_PERIOD = 10;
   localparam int SB    = 3;
   localparam int UB    = 6;
   localparam int NSUB  = 1 << SB;
   localparam int UNITS = 1 << UB;
   localparam int PU    = NSUB * UNITS;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_ctl = 1'b0, wr_lo = 1'b0, wr_hi = 1'b0;
   logic [7:0] wdata = '0;
   logic       pwm_o;

   int checks = 0;
   int fails  = 0;
   int runs [NSUB];
   int expr [NSUB];

   always #(CLK_PERIOD/2) clk = ~clk;

   spread_pwm14 #(.SUB_BITS(SB), .UNIT_BITS(UB)) i_spread_pwm14 (
      .clk(clk), .rst_n(rst_n), .wr_ctl(wr_ctl), .wr_lo(wr_lo),
      .wr_hi(wr_hi), .wdata(wdata), .pwm_o(pwm_o)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input int which, input logic [7:0] v);
      @(negedge clk);
      wdata  = v;
      wr_ctl = (which == 0);
      wr_lo  = (which == 1);
      wr_hi  = (which == 2);
      @(negedge clk);
      wr_ctl = 1'b0; wr_lo = 1'b0; wr_hi = 1'b0;
   endtask

   task automatic set_ctl(input int code, input bit en);
      wr(0, 8'(code & 3) | (en ? 8'h04 : 8'h00));
   endtask

   task automatic set_data(input int d);
      wr(1, 8'(d & 255));
      wr(2, 8'((d >> 8) & 255));
   endtask

   // waits past the next wrap, then sums high clocks over one period
   task automatic measure(input int code, output int hi);
      int p = PU << code;
      repeat (p + 8) @(negedge clk);
      hi = 0;
      repeat (p) begin
         @(negedge clk);
         if (pwm_o) hi++;
      end
   endtask

   function automatic int expect_total(input int d, input int code);
      int u = d + NSUB;
      if (u > PU) u = PU;
      return u << code;
   endfunction

   function automatic int brev(input int k);
      int r = 0;
      for (int i = 0; i < SB; i++) if (k & (1 << i)) r |= 1 << (SB - 1 - i);
      return r;
   endfunction

   task automatic wait_rise();
      logic pv = pwm_o;
      forever begin
         @(negedge clk);
         if (pwm_o && !pv) break;
         pv = pwm_o;
      end
   endtask

   // length in clocks of the run that is high now, ends at first low sample
   task automatic run_len(output int len);
      len = 0;
      while (pwm_o) begin
         len++;
         @(negedge clk);
      end
   endtask

   task automatic sub_pattern(input int d, input int code);
      int q = d / NSUB;
      int r = d % NSUB;
      int nlong = 0;
      int inband = 1;
      int match = 0;
      int len;
      set_data(d);
      repeat ((PU << code) + 8) @(negedge clk);
      wait_rise();
      for (int k = 0; k < NSUB; k++) begin
         run_len(len);
         runs[k] = len >> code;
         if (k < NSUB - 1) wait_rise();
      end
      for (int k = 0; k < NSUB; k++) begin
         expr[k] = q + 1 + ((brev(k) < r) ? 1 : 0);
         if (runs[k] == q + 2) nlong++;
         else if (runs[k] != q + 1) inband = 0;
      end
      // R4: every run is base or base+1, remainder count get base+1
      check($sformatf("R4 run band d=%0d c=%0d", d, code), inband, 1);
      check($sformatf("R4 long runs d=%0d c=%0d", d, code), nlong, r);
      for (int rot = 0; rot < NSUB; rot++) begin
         int ok = 1;
         for (int k = 0; k < NSUB; k++)
            if (runs[k] != expr[(k + rot) % NSUB]) ok = 0;
         if (ok) match = 1;
      end
      // R5: bit-reversed placement of the extra units
      check($sformatf("R5 spread order d=%0d c=%0d", d, code), match, 1);
   endtask

   initial begin
      int hi;
      int len;
      int nold;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;

      // R1: idle after reset
      hi = 0;
      repeat (40) begin
         @(negedge clk);
         if (pwm_o) hi++;
      end
      check("R1 output idle after reset", hi, 0);
      set_ctl(0, 1'b1);
      measure(0, hi);
      check("R1 reset duty is zero", hi, expect_total(0, 0));

      // R3: sweep at rate code 0 with boundaries
      for (int d = 0; d < PU; d += 11) begin
         set_data(d);
         measure(0, hi);
         check($sformatf("R3 total d=%0d c=0", d), hi, expect_total(d, 0));
      end
      foreach (expr[i]) expr[i] = 0;
      begin
         int bnd [8] = '{7, 8, 9, 503, 504, 505, 510, 511};
         foreach (bnd[i]) begin
            set_data(bnd[i]);
            measure(0, hi);
            check($sformatf("R3 boundary d=%0d", bnd[i]), hi, expect_total(bnd[i], 0));
         end
      end

      // R2: the other rate codes stretch unit and period
      for (int c = 1; c < 4; c++) begin
         int vals [3] = '{0, 100, 511};
         set_ctl(c, 1'b1);
         foreach (vals[i]) begin
            set_data(vals[i]);
            measure(c, hi);
            check($sformatf("R2 rate d=%0d c=%0d", vals[i], c), hi, expect_total(vals[i], c));
         end
      end

      // R4 R5: per-sub-pulse runs at two rates
      set_ctl(0, 1'b1);
      sub_pattern(41, 0);
      sub_pattern(83, 0);
      sub_pattern(164, 0);
      set_ctl(1, 1'b1);
      sub_pattern(29, 1);
      set_ctl(0, 1'b1);

      // R6: upper write bits above the duty width are ignored
      wr(1, 8'd60);
      wr(2, 8'hFE);
      measure(0, hi);
      check("R6 high byte masked", hi, expect_total(60, 0));
      wr(2, 8'hFF);
      measure(0, hi);
      check("R6 high byte bit8", hi, expect_total(256 + 60, 0));

      // R7: low byte alone leaves the output untouched
      set_data(40);
      wr(1, 8'd200);
      measure(0, hi);
      check("R7 low-only write", hi, expect_total(40, 0));
      wr(2, 8'd0);
      measure(0, hi);
      check("R6 high write joins stored low", hi, expect_total(200, 0));

      // R6: mid-period write keeps old duty until the wrap
      set_data(1);
      repeat (PU + 8) @(negedge clk);
      len = 0;
      while (len != 2) begin
         wait_rise();
         run_len(len);
      end
      set_data(200);
      nold = 0;
      for (int k = 0; k < NSUB - 1; k++) begin
         wait_rise();
         run_len(len);
         if (len == 1) nold++;
      end
      check("R6 old duty holds to wrap", nold, NSUB - 1);
      wait_rise();
      run_len(len);
      check("R6 new duty after wrap", len, 200 / NSUB + 1);

      // R8: disabled output sits at idle level, duty changes unseen
      set_ctl(0, 1'b0);
      set_data(300);
      measure(0, hi);
      check("R8 disabled output", hi, 0);
      set_ctl(0, 1'b1);
      measure(0, hi);
      check("R8 re-enabled output", hi, expect_total(300, 0));

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (195000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule